// File: doc/BRIEF.md
# Fixed-Point System Time Counter

This block keeps a 64-bit system time value that grows by a programmable fixed-point step on every cycle of its clock. The value is not a plain nanosecond count. Software picks a step and a binary-point position to match the link speed, and then turns the count into nanoseconds with a right shift. A step of 0x66666666 with 28 fraction bits gives a 6.4 ns clock. A step of 0x40000000 with 24 fraction bits gives a 64 ns clock. A step of 0x50000000 with 21 fraction bits gives a 640 ns clock. To trim the frequency, software rewrites the step by a few parts per billion. The running count is not disturbed when it does so.

Software reaches the block through a small word-wide register port. The port has three registers: the low time word, the high time word and the step register. The full variant keeps a 31-bit step. A reduced variant keeps a 24-bit step plus an 8-bit period field at bit 24, and it advances only while that field holds 1. Reading the low word copies the high word into a shadow register. A following read of the high word therefore returns the same 64-bit instant, even if a carry has moved the live count on in between. The live count is also driven out on a port for timestamping logic.

Top module: `systime_counter`

## Requirements
- R1: After reset the time value, the step register and the read data are all zero.
- R2: With an effective step of zero the time value holds its value from cycle to cycle.
- R3: On every cycle with no time-word write, the time value becomes the previous time value plus the effective step, modulo 2^64.
- R4: A write to the step register (address 2) is used from the next clock edge onward. The edge that stores the new step still adds the old step.
- R5: A write to the low time word (address 0) replaces bits 31:0 with the written data and keeps bits 63:32. No step is added on that edge, and accumulation resumes from the loaded value.
- R6: A write to the high time word (address 1) replaces bits 63:32 and keeps bits 31:0. No step is added on that edge.
- R7: A read of address 0 returns bits 31:0 and stores bits 63:32 of the same instant in a shadow register. A read of address 1 returns that shadow value, not the live high word.
- R8: In the full variant, a step write keeps only bits 30:0, and reading address 2 returns the stored step. Writes to address 3 change nothing, and reads of address 3 return zero.
- R9: Read data appears one clock after the read strobe and holds until the next read.
- R10: The time value wraps from all ones to zero when the step is added.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Counter clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| reg_wr | input | 1 | Write strobe |
| reg_rd | input | 1 | Read strobe |
| reg_addr | input | 2 | Register address: 0 low word, 1 high word, 2 step, 3 spare |
| reg_wdata | input | 32 | Write data |
| reg_rdata | output | 32 | Read data, registered |
| sys_time | output | 64 | Live fixed-point time value |

## Verification
Every result is due one edge after its stimulus. That covers a time-word load, a step write (which appears in the count one edge later still), the read data and the shadow capture. The bench drives inputs and compares outputs on falling edges, so each comparison sees exactly one rising edge of effect. A behavioural model is updated on each rising edge and compared on every falling edge. Directed checks add fixed values for the snapshot coherence across a carry, the wrap to zero and the step masking.

// File: rtl/systime_pkg.sv
package systime_pkg;
  localparam int WORD_W = 32;

  typedef enum logic [1:0] {
    RA_TIME_LO = 2'd0,
    RA_TIME_HI = 2'd1,
    RA_STEP    = 2'd2,
    RA_SPARE   = 2'd3
  } reg_addr_e;

  // Bits kept when the step register is written.
  function automatic logic [WORD_W-1:0] step_keep_mask(int unsigned inc_w, bit reduced);
    if (reduced) return '1;
    return (WORD_W'(1) << inc_w) - WORD_W'(1);
  endfunction

  // Next time value from the current one and the effective step.
  function automatic logic [2*WORD_W-1:0] time_advance(logic [2*WORD_W-1:0] cur,
                                                      logic [WORD_W-1:0] step);
    return cur + {{WORD_W{1'b0}}, step};
  endfunction
endpackage

// File: rtl/systime_step.sv
module systime_step
  import systime_pkg::*;
#(
  parameter int unsigned INC_W   = 31,
  parameter bit          REDUCED = 1'b0
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_stb,
  input  logic [WORD_W-1:0] wdata,
  output logic [WORD_W-1:0] step_raw,
  output logic [WORD_W-1:0] step_eff
);
  localparam logic [WORD_W-1:0] KEEP = step_keep_mask(INC_W, REDUCED);
  localparam logic [WORD_W-1:0] FIELD = step_keep_mask(INC_W, 1'b0);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) step_raw <= '0;
    else if (wr_stb) step_raw <= wdata & KEEP;
  end

  generate
    if (REDUCED) begin : g_reduced
      logic period_ok;
      assign period_ok = ((step_raw >> INC_W) == WORD_W'(1));
      assign step_eff  = period_ok ? (step_raw & FIELD) : '0;
    end else begin : g_full
      assign step_eff = step_raw;
    end
  endgenerate
endmodule

// File: rtl/systime_accum.sv
module systime_accum
  import systime_pkg::*;
(
  input  logic                clk,
  input  logic                rst_n,
  input  logic                ld_lo,
  input  logic                ld_hi,
  input  logic [WORD_W-1:0]   wdata,
  input  logic [WORD_W-1:0]   step,
  output logic [2*WORD_W-1:0] time_q
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)     time_q <= '0;
    else if (ld_lo) time_q <= {time_q[2*WORD_W-1:WORD_W], wdata};
    else if (ld_hi) time_q <= {wdata, time_q[WORD_W-1:0]};
    else            time_q <= time_advance(time_q, step);
  end
endmodule

// File: rtl/systime_readout.sv
module systime_readout
  import systime_pkg::*;
(
  input  logic                clk,
  input  logic                rst_n,
  input  logic                rd_stb,
  input  reg_addr_e           rd_sel,
  input  logic [2*WORD_W-1:0] time_q,
  input  logic [WORD_W-1:0]   step_raw,
  output logic [WORD_W-1:0]   shadow_hi,
  output logic [WORD_W-1:0]   rdata
);
  logic [WORD_W-1:0] rd_mux;

  always_comb begin
    unique case (rd_sel)
      RA_TIME_LO: rd_mux = time_q[WORD_W-1:0];
      RA_TIME_HI: rd_mux = shadow_hi;
      RA_STEP:    rd_mux = step_raw;
      default:    rd_mux = '0;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      shadow_hi <= '0;
      rdata     <= '0;
    end else if (rd_stb) begin
      rdata <= rd_mux;
      if (rd_sel == RA_TIME_LO) shadow_hi <= time_q[2*WORD_W-1:WORD_W];
    end
  end
endmodule

// File: rtl/systime_counter.sv
module systime_counter
  import systime_pkg::*;
#(
  parameter int unsigned INC_W   = 31,
  parameter bit          REDUCED = 1'b0
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        reg_wr,
  input  logic        reg_rd,
  input  logic [1:0]  reg_addr,
  input  logic [31:0] reg_wdata,
  output logic [31:0] reg_rdata,
  output logic [63:0] sys_time
);
  reg_addr_e         sel;
  logic              ld_lo, ld_hi, step_wr;
  logic [WORD_W-1:0] step_raw, step_eff, shadow_hi;

  assign sel     = reg_addr_e'(reg_addr);
  assign ld_lo   = reg_wr && (sel == RA_TIME_LO);
  assign ld_hi   = reg_wr && (sel == RA_TIME_HI);
  assign step_wr = reg_wr && (sel == RA_STEP);

  systime_step #(.INC_W(INC_W), .REDUCED(REDUCED)) u_step (
    .clk(clk), .rst_n(rst_n), .wr_stb(step_wr), .wdata(reg_wdata),
    .step_raw(step_raw), .step_eff(step_eff)
  );

  systime_accum u_accum (
    .clk(clk), .rst_n(rst_n), .ld_lo(ld_lo), .ld_hi(ld_hi),
    .wdata(reg_wdata), .step(step_eff), .time_q(sys_time)
  );

  systime_readout u_readout (
    .clk(clk), .rst_n(rst_n), .rd_stb(reg_rd), .rd_sel(sel),
    .time_q(sys_time), .step_raw(step_raw),
    .shadow_hi(shadow_hi), .rdata(reg_rdata)
  );
endmodule

// File: rtl/systime_counter_chk.sv
module systime_counter_chk
  import systime_pkg::*;
#(
  parameter int unsigned INC_W   = 31,
  parameter bit          REDUCED = 1'b0
) (
  input logic        clk,
  input logic        rst_n,
  input logic        reg_wr,
  input logic        reg_rd,
  input logic [1:0]  reg_addr,
  input logic [31:0] reg_wdata,
  input logic [31:0] reg_rdata,
  input logic [63:0] sys_time,
  input logic [31:0] step_eff,
  input logic [31:0] shadow_hi
);
  logic time_wr;
  assign time_wr = reg_wr && (reg_addr == 2'd0 || reg_addr == 2'd1);

  assert_hold_zero_step_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (step_eff == 32'd0 && !time_wr) |=> $stable(sys_time));

  assert_accumulate_R3: assert property (@(posedge clk) disable iff (!rst_n)
    !time_wr |=> sys_time == $past(sys_time) + {32'd0, $past(step_eff)});

  assert_step_update_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (!REDUCED && reg_wr && reg_addr == 2'd2)
      |=> step_eff == ($past(reg_wdata) & step_keep_mask(INC_W, 1'b0)));

  assert_load_low_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (reg_wr && reg_addr == 2'd0)
      |=> sys_time[31:0] == $past(reg_wdata) && sys_time[63:32] == $past(sys_time[63:32]));

  assert_load_high_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (reg_wr && reg_addr == 2'd1)
      |=> sys_time[63:32] == $past(reg_wdata) && sys_time[31:0] == $past(sys_time[31:0]));

  assert_shadow_capture_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (reg_rd && reg_addr == 2'd0) |=> shadow_hi == $past(sys_time[63:32]));

  assert_high_from_shadow_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (reg_rd && reg_addr == 2'd1) |=> reg_rdata == $past(shadow_hi));

  assert_read_hold_R9: assert property (@(posedge clk) disable iff (!rst_n)
    !reg_rd |=> $stable(reg_rdata));
endmodule

bind systime_counter systime_counter_chk #(.INC_W(INC_W), .REDUCED(REDUCED)) u_chk (
  .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_rd(reg_rd), .reg_addr(reg_addr),
  .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .sys_time(sys_time),
  .step_eff(step_eff), .shadow_hi(shadow_hi)
);

// File: tb/systime_counter_tb.sv
module systime_counter_tb;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        reg_wr = 1'b0, reg_rd = 1'b0;
  logic [1:0]  reg_addr = 2'd0;
  logic [31:0] reg_wdata = 32'd0;
  logic [31:0] reg_rdata;
  logic [63:0] sys_time;

  always #2 clk = ~clk;

  systime_counter u_dut (
    .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_rd(reg_rd), .reg_addr(reg_addr),
    .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .sys_time(sys_time)
  );

  // Behavioural reference
  logic [63:0] m_time;
  logic [31:0] m_step, m_shadow, m_rd;
  string cur_req = "R1";
  int vectors = 0, miscompares = 0, cycles = 0;
  bit started = 0, done = 0;

  always @(posedge clk) begin
    cycles++;
    if (!rst_n) begin
      m_time = 64'd0; m_step = 32'd0; m_shadow = 32'd0; m_rd = 32'd0;
    end else begin
      if (reg_rd) begin
        if (reg_addr == 2'd0) begin m_rd = m_time[31:0]; m_shadow = m_time[63:32]; end
        else if (reg_addr == 2'd1) m_rd = m_shadow;
        else if (reg_addr == 2'd2) m_rd = m_step;
        else m_rd = 32'd0;
      end
      if (reg_wr && reg_addr == 2'd0)      m_time[31:0]  = reg_wdata;
      else if (reg_wr && reg_addr == 2'd1) m_time[63:32] = reg_wdata;
      else                                 m_time = m_time + 64'(m_step);
      if (reg_wr && reg_addr == 2'd2) m_step = reg_wdata % 32'h8000_0000;
    end
    started = 1;
  end

  always @(negedge clk) begin
    if (started && !done) begin
      vectors++;
      if (sys_time !== m_time) begin
        miscompares++;
        $display("FAIL %s sys_time actual %h expected %h", cur_req, sys_time, m_time);
      end
      if (reg_rdata !== m_rd) begin
        miscompares++;
        $display("FAIL %s reg_rdata actual %h expected %h", cur_req, reg_rdata, m_rd);
      end
    end
  end

  task automatic check(string req, logic [63:0] act, logic [63:0] exp);
    vectors++;
    if (act !== exp) begin
      miscompares++;
      $display("FAIL %s actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic idle(int n);
    for (int i = 0; i < n; i++) @(negedge clk);
  endtask

  task automatic wr(logic [1:0] a, logic [31:0] d);
    @(negedge clk); reg_wr = 1'b1; reg_addr = a; reg_wdata = d;
    @(negedge clk); reg_wr = 1'b0;
  endtask

  task automatic rd(logic [1:0] a, output logic [31:0] v);
    @(negedge clk); reg_rd = 1'b1; reg_addr = a;
    @(negedge clk); reg_rd = 1'b0; v = reg_rdata;
  endtask

  task automatic finish_run();
    done = 1;
    $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
    $finish;
  endtask

  initial begin
    wait (cycles > 100000);
    miscompares++;
    $display("FAIL watchdog actual %0d expected <100000", cycles);
    finish_run();
  end

  initial begin
    logic [31:0] v, lo;
    logic [63:0] t0;
    idle(3);
    check("R1", {sys_time[31:0], reg_rdata}, 64'd0);
    rst_n = 1'b1;
    cur_req = "R2"; idle(5);
    check("R2", sys_time, 64'd0);
    cur_req = "R4"; wr(2'd2, 32'h6666_6666);
    check("R4", sys_time, 64'd0);
    @(negedge clk); check("R4", sys_time, 64'h6666_6666);
    cur_req = "R3"; idle(20);
    t0 = sys_time; @(negedge clk);
    check("R3", sys_time, t0 + 64'h6666_6666);
    cur_req = "R8"; wr(2'd2, 32'hFFFF_FFFF); rd(2'd2, v);
    check("R8", {32'd0, v}, 64'h7FFF_FFFF);
    cur_req = "R9"; idle(3); check("R9", {32'd0, reg_rdata}, 64'h7FFF_FFFF);
    cur_req = "R5"; wr(2'd0, 32'hFFFF_FFF0); idle(4);
    wr(2'd2, 32'h0); idle(2);
    cur_req = "R6"; wr(2'd1, 32'h0000_0007); check("R6", sys_time[63:32], 64'd7);
    cur_req = "R5"; wr(2'd0, 32'hFFFF_FF80);
    check("R5", sys_time, 64'h0000_0007_FFFF_FF80);
    cur_req = "R8"; wr(2'd3, 32'hDEAD_BEEF); rd(2'd3, v);
    check("R8", {32'd0, v}, 64'd0);
    check("R8", sys_time, 64'h0000_0007_FFFF_FF80);
    cur_req = "R7"; rd(2'd0, lo);
    check("R7", {32'd0, lo}, 64'hFFFF_FF80);
    wr(2'd2, 32'h80); @(negedge clk);
    check("R7", sys_time, 64'h0000_0008_0000_0000);
    rd(2'd1, v);
    check("R7", {32'd0, v}, 64'd7);
    cur_req = "R10"; wr(2'd2, 32'h0);
    wr(2'd1, 32'hFFFF_FFFF); wr(2'd0, 32'hFFFF_FFFF);
    wr(2'd2, 32'h1);
    check("R10", sys_time, 64'hFFFF_FFFF_FFFF_FFFF);
    @(negedge clk); check("R10", sys_time, 64'd0);
    cur_req = "R3"; wr(2'd2, 32'h4000_0000); idle(10);
    wr(2'd2, 32'h5000_0000); idle(10);
    finish_run();
  end
endmodule